// File: doc/BRIEF.md
# Tag-Driven Operand Dispatch Unit

This unit sits between instruction decode and the execution units of a core whose 64-bit registers carry a type tag in their uppermost bits. Decode hands it a generic arithmetic operation code. The register path supplies the two source values, each with a flag that says the value has arrived. The unit looks at the two tags and picks the target at run time. Two fixnums go to the integer ALU and two flonums go to the FPU. A fixnum paired with a flonum first goes through an FPU conversion step and then through the float operation itself. Any other pairing raises a type fault.

The unit handles one operation at a time. An accepted operation takes one unpack cycle and then waits in a specialise stage until both operand flags are high. Decode is stalled for the whole of that wait. Each unit port follows a valid/ready handshake. The conversion result comes back on a response port and is held in a temporary register until the second FPU request is issued.

Top module: `tdu_dispatch`

## Requirements
- R1: After reset, `in_ready` is 1 and `alu_valid`, `fpu_valid` and `type_fault` are all 0.
- R2: The class of an operand comes from its bits [63:62]: 01 is a fixnum and 10 is a flonum. When both operands are fixnums, exactly one ALU request is issued with `alu_op`, `alu_a` and `alu_b` equal to the accepted op code and the two operands in their original order, and no FPU request is issued.
- R3: When both operands are flonums, exactly one FPU request is issued with `fpu_cvt`=0, the accepted op code and the operands in their original order, and no ALU request is issued.
- R4: With one fixnum and one flonum, the first FPU request has `fpu_cvt`=1 and carries the fixnum in `fpu_a`. After that request is accepted, `fpu_valid` stays 0 until `fpu_rsp_valid` is seen. The next request then has `fpu_cvt`=0 and the original op code.
- R5: In the mixed case, the second request puts the converted value in the slot where the fixnum was and keeps the flonum in its own slot, so operand order is preserved.
- R6: When bits [63:62] are 00 (object reference, with subtag [61:60] 00 pointer, 01 unassigned, 1x bounded array) or 11 (other class, with subtag 00 for small value types), and this holds for either operand, `type_fault` is high for exactly one cycle and no request is issued to either unit.
- R7: While `src_a_ok` or `src_b_ok` is 0, nothing is issued and `in_ready` stays 0. The request appears in the cycle after the edge at which both flags are 1.
- R8: When the operands are ready at once, the request (or the fault) appears after the second clock edge that follows the accepting edge.
- R9: A pending request keeps its valid and payload unchanged until the unit's ready is sampled high.
- R10: `in_ready` is 0 from the accepting edge until the last handshake of the operation, and `in_valid` has no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decode offers an operation |
| in_op | input | 3 | Generic operation code |
| in_ready | output | 1 | Unit is able to accept an operation |
| src_a | input | 64 | First operand value with tag |
| src_a_ok | input | 1 | First operand has arrived |
| src_b | input | 64 | Second operand value with tag |
| src_b_ok | input | 1 | Second operand has arrived |
| alu_valid | output | 1 | ALU request valid |
| alu_ready | input | 1 | ALU takes the request |
| alu_op | output | 3 | ALU operation code |
| alu_a | output | 64 | ALU first operand |
| alu_b | output | 64 | ALU second operand |
| fpu_valid | output | 1 | FPU request valid |
| fpu_ready | input | 1 | FPU takes the request |
| fpu_cvt | output | 1 | Request is a fixnum-to-float conversion |
| fpu_op | output | 3 | FPU operation code |
| fpu_a | output | 64 | FPU first operand (the value to convert when `fpu_cvt`=1) |
| fpu_b | output | 64 | FPU second operand |
| fpu_rsp_valid | input | 1 | Conversion result is present |
| fpu_rsp_data | input | 64 | Conversion result |
| type_fault | output | 1 | One-cycle pulse for a non-numeric operand pair |

## Verification
The mixed case is tested in both directions with a subtract. A design that converts the wrong operand, or that always puts the converted value in `fpu_a`, sends mismatched operands in the second request. The bench also holds back the conversion response for several cycles, which exposes a design that issues the float step before the temporary is loaded. Pointer, unassigned, array and small-value tags are each paired with numeric operands, and a design that lets one of them through issues a request where a fault pulse is expected. The remaining tests hold an operand flag low, keep a unit's ready low while decode offers another operation, and count the cycles to the first request. These expose early issue, requests that change before they are accepted, and operations that should have been ignored.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
  localparam int TAGW = 4;

  typedef enum logic [2:0] {
    CL_FIX, CL_FLO, CL_PTR, CL_ARR, CL_UNA, CL_SMALL, CL_OTH
  } cls_e;

  typedef enum logic [1:0] {
    RT_ALU, RT_FPU, RT_CVT, RT_FAULT
  } route_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNPK, S_SPEC, S_ALU, S_FPU, S_CVT, S_CWAIT, S_FLT
  } st_e;
endpackage

// File: rtl/tdu_rst_sync.sv
module tdu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tdu_tag_class.sv
module tdu_tag_class
  import tdu_pkg::*;
(
  input  logic [TAGW-1:0] tag,
  output cls_e            cls
);
  always_comb begin
    unique case (tag[3:2])
      2'b01: cls = CL_FIX;
      2'b10: cls = CL_FLO;
      2'b00: begin
        if (tag[1])           cls = CL_ARR;
        else if (tag[0])      cls = CL_UNA;
        else                  cls = CL_PTR;
      end
      default: cls = (tag[1:0] == 2'b00) ? CL_SMALL : CL_OTH;
    endcase
  end
endmodule

// File: rtl/tdu_route.sv
module tdu_route
  import tdu_pkg::*;
(
  input  cls_e   cls_a,
  input  cls_e   cls_b,
  output route_e route,
  output logic   cvt_b
);
  always_comb begin
    cvt_b = 1'b0;
    route = RT_FAULT;
    if (cls_a == CL_FIX && cls_b == CL_FIX) begin
      route = RT_ALU;
    end else if (cls_a == CL_FLO && cls_b == CL_FLO) begin
      route = RT_FPU;
    end else if (cls_a == CL_FIX && cls_b == CL_FLO) begin
      route = RT_CVT;
    end else if (cls_a == CL_FLO && cls_b == CL_FIX) begin
      route = RT_CVT;
      cvt_b = 1'b1;
    end
  end
endmodule

// File: rtl/tdu_seq.sv
module tdu_seq
  import tdu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int OPW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  in_op,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic            opnd_ok,
  input  route_e          route,
  input  logic            cvt_b,
  input  logic            alu_ready,
  input  logic            fpu_ready,
  input  logic            fpu_rsp_valid,
  input  logic [XLEN-1:0] fpu_rsp_data,
  output logic            in_ready,
  output logic            alu_valid,
  output logic [OPW-1:0]  alu_op,
  output logic [XLEN-1:0] alu_a,
  output logic [XLEN-1:0] alu_b,
  output logic            fpu_valid,
  output logic            fpu_cvt,
  output logic [OPW-1:0]  fpu_op,
  output logic [XLEN-1:0] fpu_a,
  output logic [XLEN-1:0] fpu_b,
  output logic            type_fault
);
  st_e             state_q, state_d;
  logic [OPW-1:0]  op_q;
  logic [XLEN-1:0] a_q, b_q, tmp_q;
  logic            cvtb_q, mix_q;
  logic            op_en, opnd_en, tmp_en;

  assign op_en   = (state_q == S_IDLE) && in_valid;
  assign opnd_en = (state_q == S_SPEC) && opnd_ok;
  assign tmp_en  = (state_q == S_CWAIT) && fpu_rsp_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (in_valid) state_d = S_UNPK;
      S_UNPK:  state_d = S_SPEC;
      S_SPEC: begin
        if (opnd_ok) begin
          unique case (route)
            RT_ALU:  state_d = S_ALU;
            RT_FPU:  state_d = S_FPU;
            RT_CVT:  state_d = S_CVT;
            default: state_d = S_FLT;
          endcase
        end
      end
      S_ALU:   if (alu_ready) state_d = S_IDLE;
      S_CVT:   if (fpu_ready) state_d = S_CWAIT;
      S_CWAIT: if (fpu_rsp_valid) state_d = S_FPU;
      S_FPU:   if (fpu_ready) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (op_en) op_q <= in_op;
    if (opnd_en) begin
      a_q    <= src_a;
      b_q    <= src_b;
      cvtb_q <= cvt_b;
      mix_q  <= (route == RT_CVT);
    end
    if (tmp_en) tmp_q <= fpu_rsp_data;
  end

  assign in_ready   = (state_q == S_IDLE);
  assign type_fault = (state_q == S_FLT);

  assign alu_valid = (state_q == S_ALU);
  assign alu_op    = op_q;
  assign alu_a     = a_q;
  assign alu_b     = b_q;

  assign fpu_valid = (state_q == S_FPU) || (state_q == S_CVT);
  assign fpu_cvt   = (state_q == S_CVT);
  assign fpu_op    = op_q;

  always_comb begin
    fpu_a = a_q;
    fpu_b = b_q;
    if (state_q == S_CVT) begin
      fpu_a = cvtb_q ? b_q : a_q;
      fpu_b = '0;
    end else if (mix_q) begin
      if (cvtb_q) fpu_b = tmp_q;
      else        fpu_a = tmp_q;
    end
  end
endmodule

// File: rtl/tdu_dispatch.sv
module tdu_dispatch
  import tdu_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int OPW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [OPW-1:0]  in_op,
  output logic            in_ready,
  input  logic [XLEN-1:0] src_a,
  input  logic            src_a_ok,
  input  logic [XLEN-1:0] src_b,
  input  logic            src_b_ok,
  output logic            alu_valid,
  input  logic            alu_ready,
  output logic [OPW-1:0]  alu_op,
  output logic [XLEN-1:0] alu_a,
  output logic [XLEN-1:0] alu_b,
  output logic            fpu_valid,
  input  logic            fpu_ready,
  output logic            fpu_cvt,
  output logic [OPW-1:0]  fpu_op,
  output logic [XLEN-1:0] fpu_a,
  output logic [XLEN-1:0] fpu_b,
  input  logic            fpu_rsp_valid,
  input  logic [XLEN-1:0] fpu_rsp_data,
  output logic            type_fault
);
  localparam int NSRC = 2;

  logic                rst_sync_n;
  logic [XLEN-1:0]     srcs [NSRC];
  cls_e                cls  [NSRC];
  route_e              route;
  logic                cvt_b;

  assign srcs[0] = src_a;
  assign srcs[1] = src_b;

  tdu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_cls
    tdu_tag_class u_cls (
      .tag(srcs[g][XLEN-1 -: TAGW]),
      .cls(cls[g])
    );
  end

  tdu_route u_route (
    .cls_a(cls[0]), .cls_b(cls[1]), .route(route), .cvt_b(cvt_b)
  );

  tdu_seq #(.XLEN(XLEN), .OPW(OPW)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .in_valid(in_valid), .in_op(in_op),
    .src_a(src_a), .src_b(src_b),
    .opnd_ok(src_a_ok && src_b_ok),
    .route(route), .cvt_b(cvt_b),
    .alu_ready(alu_ready), .fpu_ready(fpu_ready),
    .fpu_rsp_valid(fpu_rsp_valid), .fpu_rsp_data(fpu_rsp_data),
    .in_ready(in_ready),
    .alu_valid(alu_valid), .alu_op(alu_op), .alu_a(alu_a), .alu_b(alu_b),
    .fpu_valid(fpu_valid), .fpu_cvt(fpu_cvt), .fpu_op(fpu_op),
    .fpu_a(fpu_a), .fpu_b(fpu_b),
    .type_fault(type_fault)
  );
endmodule

// File: rtl/tdu_dispatch_chk.sv
module tdu_dispatch_chk #(
  parameter int XLEN = 64,
  parameter int OPW  = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            alu_valid,
  input logic            alu_ready,
  input logic [OPW-1:0]  alu_op,
  input logic [XLEN-1:0] alu_a,
  input logic [XLEN-1:0] alu_b,
  input logic            fpu_valid,
  input logic            fpu_ready,
  input logic            fpu_cvt,
  input logic [OPW-1:0]  fpu_op,
  input logic [XLEN-1:0] fpu_a,
  input logic [XLEN-1:0] fpu_b,
  input logic            fpu_rsp_valid,
  input logic            type_fault
);
  a_r6_fault_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    type_fault |-> (!alu_valid && !fpu_valid));

  a_r6_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    type_fault |=> !type_fault);

  a_r2_one_unit: assert property (@(posedge clk) disable iff (!rst_n)
    !(alu_valid && fpu_valid));

  a_r9_alu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid && !alu_ready) |=>
      (alu_valid && $stable(alu_op) && $stable(alu_a) && $stable(alu_b)));

  a_r9_fpu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fpu_valid && !fpu_ready) |=>
      (fpu_valid && $stable(fpu_cvt) && $stable(fpu_op) &&
       $stable(fpu_a) && $stable(fpu_b)));

  a_r4_wait_result: assert property (@(posedge clk) disable iff (!rst_n)
    (fpu_valid && fpu_ready && fpu_cvt) |=> !fpu_valid);

  a_r4_cvt_then_op: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fpu_cvt) && fpu_valid) |-> $past(fpu_rsp_valid));

  a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_valid || fpu_valid || type_fault) |-> !in_ready);
endmodule

bind tdu_dispatch tdu_dispatch_chk #(.XLEN(XLEN), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_ready(in_ready),
  .alu_valid(alu_valid), .alu_ready(alu_ready), .alu_op(alu_op),
  .alu_a(alu_a), .alu_b(alu_b),
  .fpu_valid(fpu_valid), .fpu_ready(fpu_ready), .fpu_cvt(fpu_cvt),
  .fpu_op(fpu_op), .fpu_a(fpu_a), .fpu_b(fpu_b),
  .fpu_rsp_valid(fpu_rsp_valid), .type_fault(type_fault)
);

// File: tb/sim_tdu_dispatch.sv
module sim_tdu_dispatch;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;
  localparam int OPW  = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid, src_a_ok, src_b_ok;
  logic [OPW-1:0]  in_op;
  logic            in_ready;
  logic [XLEN-1:0] src_a, src_b;
  logic            alu_valid, alu_ready, fpu_valid, fpu_ready, fpu_cvt;
  logic [OPW-1:0]  alu_op, fpu_op;
  logic [XLEN-1:0] alu_a, alu_b, fpu_a, fpu_b, fpu_rsp_data;
  logic            fpu_rsp_valid, type_fault;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdu_dispatch #(.XLEN(XLEN), .OPW(OPW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_ready(in_ready), .src_a(src_a), .src_a_ok(src_a_ok),
    .src_b(src_b), .src_b_ok(src_b_ok),
    .alu_valid(alu_valid), .alu_ready(alu_ready), .alu_op(alu_op),
    .alu_a(alu_a), .alu_b(alu_b),
    .fpu_valid(fpu_valid), .fpu_ready(fpu_ready), .fpu_cvt(fpu_cvt),
    .fpu_op(fpu_op), .fpu_a(fpu_a), .fpu_b(fpu_b),
    .fpu_rsp_valid(fpu_rsp_valid), .fpu_rsp_data(fpu_rsp_data),
    .type_fault(type_fault)
  );

  function automatic logic [63:0] mk(input logic [3:0] tag, input logic [59:0] v);
    return {tag, v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Offer an op; returns at the negedge after the accepting edge.
  task automatic offer(input logic [2:0] op, input logic [63:0] a,
                       input logic [63:0] b);
    src_a = a; src_b = b; in_op = op; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // sel 0: alu_valid, 1: fpu_valid, 2: type_fault. Counts negedges from accept.
  task automatic wait_for(input int sel, output int n);
    bit hit;
    n = 1;
    for (int i = 0; i < 40; i++) begin
      hit = (sel == 0) ? alu_valid : (sel == 1) ? fpu_valid : type_fault;
      if (hit) break;
      @(negedge clk);
      n++;
    end
  endtask

  task automatic fpu_accept();
    fpu_ready = 1'b1;
    @(negedge clk);
    fpu_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk(in_ready === 1'b1, "R1 in_ready", {63'd0, in_ready}, 64'd1);
    chk(alu_valid === 1'b0 && fpu_valid === 1'b0, "R1 no request",
        {62'd0, alu_valid, fpu_valid}, 64'd0);
    chk(type_fault === 1'b0, "R1 no fault", {63'd0, type_fault}, 64'd0);
  endtask

  task automatic t_fix_fix();
    int n;
    logic [63:0] a = mk(4'b0100, 60'h123), b = mk(4'b0111, 60'h456);
    offer(3'd2, a, b);
    wait_for(0, n);
    chk(n == 3, "R8 alu latency", n, 3);
    chk(alu_op == 3'd2 && alu_a == a && alu_b == b, "R2 alu payload", alu_a, a);
    chk(fpu_valid == 1'b0, "R2 no fpu", {63'd0, fpu_valid}, 0);
    repeat (3) @(negedge clk);
    chk(alu_valid && alu_a == a && alu_b == b && alu_op == 3'd2, "R9 alu hold",
        alu_b, b);
    alu_ready = 1'b1;
    @(negedge clk);
    alu_ready = 1'b0;
    chk(!alu_valid && in_ready, "R2 single alu request", {62'd0, alu_valid, in_ready}, 1);
  endtask

  task automatic t_flo_flo();
    int n;
    logic [63:0] a = mk(4'b1000, 60'hABC), b = mk(4'b1011, 60'hDEF);
    offer(3'd5, a, b);
    wait_for(1, n);
    chk(n == 3, "R8 fpu latency", n, 3);
    chk(fpu_cvt == 1'b0 && fpu_op == 3'd5 && fpu_a == a && fpu_b == b,
        "R3 fpu payload", fpu_a, a);
    chk(alu_valid == 1'b0, "R3 no alu", {63'd0, alu_valid}, 0);
    fpu_accept();
    chk(!fpu_valid && in_ready, "R3 single fpu request", {62'd0, fpu_valid, in_ready}, 1);
  endtask

  task automatic t_mixed(input bit fix_is_b);
    int n;
    logic [63:0] fx = mk(4'b0101, 60'h77), fl = mk(4'b1001, 60'h99);
    logic [63:0] cv = mk(4'b1010, 60'h5A5A);
    logic [63:0] a = fix_is_b ? fl : fx;
    logic [63:0] b = fix_is_b ? fx : fl;
    offer(3'd1, a, b);
    wait_for(1, n);
    chk(fpu_cvt == 1'b1 && fpu_a == fx, "R4 convert request", fpu_a, fx);
    chk(alu_valid == 1'b0, "R4 no alu", {63'd0, alu_valid}, 0);
    fpu_accept();
    for (int i = 0; i < 4; i++) begin
      chk(fpu_valid == 1'b0, "R4 wait for result", {63'd0, fpu_valid}, 0);
      @(negedge clk);
    end
    fpu_rsp_data = cv; fpu_rsp_valid = 1'b1;
    @(negedge clk);
    fpu_rsp_valid = 1'b0; fpu_rsp_data = '0;
    chk(fpu_valid && !fpu_cvt && fpu_op == 3'd1, "R4 second request",
        {61'd0, fpu_valid, fpu_cvt, 1'b0}, 64'd4);
    if (fix_is_b)
      chk(fpu_a == fl && fpu_b == cv, "R5 order b converted", fpu_b, cv);
    else
      chk(fpu_a == cv && fpu_b == fl, "R5 order a converted", fpu_a, cv);
    fpu_accept();
    chk(!fpu_valid && in_ready, "R4 sequence done", {62'd0, fpu_valid, in_ready}, 1);
  endtask

  task automatic t_fault(input logic [3:0] tag_a, input logic [3:0] tag_b,
                         input string what);
    int n;
    offer(3'd0, mk(tag_a, 60'h1), mk(tag_b, 60'h2));
    wait_for(2, n);
    chk(n == 3, {"R6 fault timing ", what}, n, 3);
    chk(!alu_valid && !fpu_valid, {"R6 no issue ", what},
        {62'd0, alu_valid, fpu_valid}, 0);
    @(negedge clk);
    chk(!type_fault && in_ready, {"R6 one-cycle pulse ", what},
        {62'd0, type_fault, in_ready}, 1);
    for (int i = 0; i < 3; i++) begin
      chk(!alu_valid && !fpu_valid, {"R6 stays quiet ", what},
          {62'd0, alu_valid, fpu_valid}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_stall();
    logic [63:0] a = mk(4'b0100, 60'h3), b = mk(4'b0100, 60'h4);
    src_b_ok = 1'b0;
    offer(3'd3, a, b);
    for (int i = 0; i < 6; i++) begin
      chk(!alu_valid && !fpu_valid && !in_ready, "R7 stall while pending",
          {61'd0, alu_valid, fpu_valid, in_ready}, 0);
      @(negedge clk);
    end
    src_b_ok = 1'b1;
    @(negedge clk);
    chk(alu_valid && alu_a == a && alu_b == b, "R7 issue after ready", alu_b, b);
    alu_ready = 1'b1;
    @(negedge clk);
    alu_ready = 1'b0;
  endtask

  task automatic t_busy_ignore();
    int n;
    logic [63:0] a = mk(4'b0100, 60'h10), b = mk(4'b0100, 60'h20);
    offer(3'd6, a, b);
    wait_for(0, n);
    chk(!in_ready, "R10 busy while pending", {63'd0, in_ready}, 0);
    in_op = 3'd7; in_valid = 1'b1;
    src_a = mk(4'b1000, 60'h0); src_b = mk(4'b1000, 60'h0);
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    chk(alu_valid && alu_op == 3'd6 && alu_a == a, "R10 offer ignored",
        {61'd0, alu_op}, 6);
    alu_ready = 1'b1;
    @(negedge clk);
    alu_ready = 1'b0;
    for (int i = 0; i < 5; i++) begin
      chk(in_ready && !alu_valid && !fpu_valid, "R10 no phantom op",
          {61'd0, in_ready, alu_valid, fpu_valid}, 4);
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0;
    src_a = '0; src_b = '0; src_a_ok = 1'b1; src_b_ok = 1'b1;
    alu_ready = 1'b0; fpu_ready = 1'b0; fpu_rsp_valid = 1'b0; fpu_rsp_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_fix_fix();
    t_flo_flo();
    t_mixed(1'b0);
    t_mixed(1'b1);
    t_fault(4'b0000, 4'b0100, "pointer");
    t_fault(4'b1000, 4'b0001, "unassigned");
    t_fault(4'b0010, 4'b1000, "array");
    t_fault(4'b0100, 4'b1100, "small value");
    t_fault(4'b1101, 4'b1111, "other");
    t_stall();
    t_busy_ignore();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule